// File: doc/BRIEF.md
# Software Interrupt Trigger Decoder

This block sits behind the register write port of an interrupt distributor and watches for writes to the software-interrupt trigger register. Each accepted write names one of 16 software interrupt IDs and a target rule. The block turns that write into a one-cycle set-pending strobe for every processor it selects. The strobe goes out together with the ID and the index of the processor that made the request, so the pending logic downstream can later report the source in bits [12:10] of the acknowledge word. Priority arbitration among pending interrupts happens after this block.

A target rule picks processors in one of three ways: from an explicit one-bit-per-processor list, as every processor except the requester, or as the requester alone. Before any strobe is raised, a security check compares the write's non-secure attribute bit with the group configured for the requested ID. A mismatch suppresses the request.

Control is a two-state machine. `ST_IDLE` waits for a trigger write. `ST_FIRE` drives the registered strobe mask for exactly one cycle. Transitions: `GO_FIRE` (IDLE to FIRE) on a trigger write whose resolved mask is non-empty; `REFIRE` (FIRE to FIRE) when another such write arrives in the firing cycle; `DONE` (FIRE to IDLE) when none does; `STAY` (IDLE to IDLE) otherwise.

Top module: `sgi_trigger_decoder`

## Requirements
- R1: A write with `wr_en` high and `wr_addr` equal to the trigger offset (default 0xF00) that resolves to a non-empty target set raises `pend_strobe` in the cycle after the write, for exactly one cycle. A write to any other address produces no strobe.
- R2: While strobing, `pend_id` equals write data bits [3:0].
- R3: Filter value 0 (bits [25:24]) selects the explicit list in bits [23:16]: list bit i targets processor i. List bits at or above `NUM_CPU` are dropped.
- R4: Filter value 1 targets every processor below `NUM_CPU` except the requester `req_cpu`.
- R5: Filter value 2 targets only the requester, and only if `req_cpu` is below `NUM_CPU`.
- R6: Filter value 3 is reserved and produces no strobe.
- R7: Bit 15 of the write data is the non-secure attribute. A strobe is raised only if it equals `grp_cfg[id]` (1 = group 1). On a mismatch, no processor is strobed.
- R8: While strobing, `pend_src` equals the `req_cpu` value of the triggering write.
- R9: Filter 0 with an empty list produces no strobe.
- R10: During and directly after reset, `pend_strobe` is all zero.
- R11: Back-to-back trigger writes on consecutive cycles each produce their own strobe on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write offset |
| wr_data | input | 32 | Register write data |
| req_cpu | input | IDX_W | Index of the writing processor |
| grp_cfg | input | 16 | Group of each software ID, 1 = group 1 |
| pend_strobe | output | NUM_CPU | Per-processor set-pending pulse |
| pend_id | output | 4 | Software interrupt ID for the strobe |
| pend_src | output | IDX_W | Source processor index for the acknowledge word |

## Verification
The embedded properties check the following on every cycle:
- a strobe never appears without a trigger write in the previous cycle;
- a reserved filter or an attribute/group mismatch always yields an empty strobe;
- the self filter yields at most one target;
- the others filter never hits the requester;
- the ID and source fields follow the triggering write.

Only the bench scenarios can show that the exact target sets are right. The bench sweeps every ID, filter, requester index and attribute value under two group patterns, with the processor count cut to six. That cut exercises the dropping of list bits above the count and the handling of out-of-range requesters. The scenarios also cover the one-cycle pulse width, wrong-address writes and back-to-back triggers.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
    typedef enum logic [1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_RSVD   = 2'd3
    } sgi_filter_e;

    localparam int ID_LSB     = 0;
    localparam int ID_W       = 4;
    localparam int NSATTR_BIT = 15;
    localparam int LIST_LSB   = 16;
    localparam int LIST_W     = 8;
    localparam int FILT_LSB   = 24;
    localparam int NUM_IDS    = 1 << ID_W;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [LIST_W-1:0] list;
        sgi_filter_e       filt;
        logic              nsattr;
    } sgi_req_t;
endpackage

// File: rtl/sgi_field_decode.sv
module sgi_field_decode
    import sgi_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] TRIG_OFS = 12'hF00
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic              hit,
    output sgi_req_t          req
);
    always_comb begin
        hit        = wr_en && (wr_addr == TRIG_OFS);
        req.id     = wr_data[ID_LSB +: ID_W];
        req.list   = wr_data[LIST_LSB +: LIST_W];
        req.filt   = sgi_filter_e'(wr_data[FILT_LSB +: 2]);
        req.nsattr = wr_data[NSATTR_BIT];
    end
endmodule

// File: rtl/sgi_target_resolve.sv
module sgi_target_resolve
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int IDX_W   = 3
) (
    input  sgi_req_t             req,
    input  logic [IDX_W-1:0]     req_cpu,
    input  logic [NUM_IDS-1:0]   grp_cfg,
    output logic [NUM_CPU-1:0]   mask
);
    logic allowed;
    assign allowed = (req.nsattr == grp_cfg[req.id]);

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
        logic is_req;
        logic in_list;
        assign is_req = (req_cpu == IDX_W'(i));
        if (i < LIST_W) begin : g_listbit
            assign in_list = req.list[i];
        end else begin : g_nolist
            assign in_list = 1'b0;
        end
        always_comb begin
            mask[i] = 1'b0;
            if (allowed) begin
                unique case (req.filt)
                    FLT_LIST:   mask[i] = in_list;
                    FLT_OTHERS: mask[i] = !is_req;
                    FLT_SELF:   mask[i] = is_req;
                    FLT_RSVD:   mask[i] = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/sgi_trigger_decoder.sv
module sgi_trigger_decoder
    import sgi_pkg::*;
#(
    parameter int                NUM_CPU  = 8,
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] TRIG_OFS = 12'hF00,
    localparam int               IDX_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [IDX_W-1:0]   req_cpu,
    input  logic [NUM_IDS-1:0] grp_cfg,
    output logic [NUM_CPU-1:0] pend_strobe,
    output logic [ID_W-1:0]    pend_id,
    output logic [IDX_W-1:0]   pend_src
);
    localparam logic [NUM_CPU-1:0] STRB_ONE = NUM_CPU'(1);

    typedef enum logic {ST_IDLE = 1'b0, ST_FIRE = 1'b1} state_e;

    state_e             state_q, state_d;
    logic               hit;
    sgi_req_t           req;
    logic [NUM_CPU-1:0] mask_now, mask_q;
    logic [ID_W-1:0]    id_q;
    logic [IDX_W-1:0]   src_q;
    logic               launch;

    sgi_field_decode #(.ADDR_W(ADDR_W), .TRIG_OFS(TRIG_OFS)) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hit(hit), .req(req)
    );

    sgi_target_resolve #(.NUM_CPU(NUM_CPU), .IDX_W(IDX_W)) u_res (
        .req(req), .req_cpu(req_cpu), .grp_cfg(grp_cfg), .mask(mask_now)
    );

    assign launch = hit && (mask_now != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = launch ? ST_FIRE : ST_IDLE;
            ST_FIRE: state_d = launch ? ST_FIRE : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
            id_q    <= '0;
            src_q   <= '0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                mask_q <= mask_now;
                id_q   <= req.id;
                src_q  <= req_cpu;
            end
        end
    end

    always_comb begin
        pend_strobe = '0;
        pend_id     = id_q;
        pend_src    = src_q;
        unique case (state_q)
            ST_IDLE: pend_strobe = '0;
            ST_FIRE: pend_strobe = mask_q;
        endcase
    end

    // R1
    strobe_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_strobe != '0) |-> $past(wr_en && (wr_addr == TRIG_OFS)));
    // R7
    attr_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && (wr_data[NSATTR_BIT] != grp_cfg[wr_data[ID_W-1:0]])) |-> (pend_strobe == '0));
    // R6
    rsvd_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && (wr_data[FILT_LSB +: 2] == 2'd3)) |-> (pend_strobe == '0));
    // R5
    self_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && (wr_data[FILT_LSB +: 2] == 2'd2)) |-> $onehot0(pend_strobe));
    // R4
    others_skip_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && (wr_data[FILT_LSB +: 2] == 2'd1)) |-> ((pend_strobe & (STRB_ONE << $past(req_cpu))) == '0));
    // R2
    id_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_strobe != '0) |-> (pend_id == $past(wr_data[ID_W-1:0])));
    // R8
    src_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_strobe != '0) |-> (pend_src == $past(req_cpu)));
endmodule

// File: tb/sgi_trigger_decoder_tb.sv
`timescale 1ns/1ps
module sgi_trigger_decoder_tb_top;
    localparam int N     = 6;
    localparam int IDX_W = 3;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            wr_en;
    logic [11:0]     wr_addr;
    logic [31:0]     wr_data;
    logic [IDX_W-1:0] req_cpu;
    logic [15:0]     grp_cfg;
    logic [N-1:0]    pend_strobe;
    logic [3:0]      pend_id;
    logic [IDX_W-1:0] pend_src;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sgi_trigger_decoder #(.NUM_CPU(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .req_cpu(req_cpu), .grp_cfg(grp_cfg),
        .pend_strobe(pend_strobe), .pend_id(pend_id), .pend_src(pend_src)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] expect_mask(int id, int filt, int req,
            logic [7:0] list, bit attr, logic [15:0] grp);
        logic [N-1:0] all = '1;
        if (attr != grp[id]) return '0;
        case (filt)
            0: return list[N-1:0];
            1: return all & ~(N'(1) << req);
            2: return (req < N) ? (N'(1) << req) : '0;
            default: return '0;
        endcase
    endfunction

    function automatic logic [31:0] mk(int id, int filt, logic [7:0] list, bit attr);
        return {6'd0, 2'(filt), list, attr, 11'd0, 4'(id)};
    endfunction

    function automatic string tag_of(int filt, bit mism);
        if (mism) return "R7";
        case (filt)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic drive(logic [11:0] a, logic [31:0] d, int req);
        wr_en = 1'b1; wr_addr = a; wr_data = d; req_cpu = IDX_W'(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] e;
        logic [15:0] pats [2];
        pats[0] = 16'h0FF0;
        pats[1] = 16'hA5C3;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        req_cpu = '0; grp_cfg = pats[0];
        repeat (3) @(negedge clk);
        check("R10 strobe in reset", 32'(pend_strobe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 strobe after reset", 32'(pend_strobe), 0);

        for (int p = 0; p < 2; p++) begin
            grp_cfg = pats[p];
            for (int id = 0; id < 16; id++)
            for (int f = 0; f < 4; f++)
            for (int r = 0; r < 8; r++)
            for (int at = 0; at < 2; at++) begin
                logic [7:0] lst = 8'((id * 37 + r * 11 + p * 5) ^ 8'hA5);
                drive(12'hF00, mk(id, f, lst, at[0]), r);
                @(negedge clk);
                wr_en = 1'b0;
                e = expect_mask(id, f, r, lst, at[0], grp_cfg);
                check(tag_of(f, at[0] != grp_cfg[id]), 32'(pend_strobe), 32'(e));
                if (e != '0) begin
                    check("R2 id", 32'(pend_id), 32'(id));
                    check("R8 src", 32'(pend_src), 32'(r));
                end
                @(negedge clk);
                check("R1 single-cycle pulse", 32'(pend_strobe), 0);
            end
        end

        grp_cfg = 16'h0000;
        drive(12'hF00, mk(3, 0, 8'h00, 1'b0), 1);
        @(negedge clk); wr_en = 1'b0;
        check("R9 empty list", 32'(pend_strobe), 0);

        drive(12'hF00, mk(3, 0, 8'hC0, 1'b0), 1);
        @(negedge clk); wr_en = 1'b0;
        check("R3 list above count", 32'(pend_strobe), 0);

        drive(12'hF04, mk(3, 1, 8'hFF, 1'b0), 1);
        @(negedge clk); wr_en = 1'b0;
        check("R1 wrong address", 32'(pend_strobe), 0);
        drive(12'h700, mk(3, 0, 8'h3F, 1'b0), 1);
        @(negedge clk); wr_en = 1'b0;
        check("R1 wrong address", 32'(pend_strobe), 0);

        drive(12'hF00, mk(5, 0, 8'h05, 1'b0), 2);
        @(negedge clk);
        check("R11 first", 32'(pend_strobe), 32'h05);
        drive(12'hF00, mk(9, 2, 8'h00, 1'b0), 4);
        @(negedge clk);
        check("R11 second", 32'(pend_strobe), 32'h10);
        check("R11 second id", 32'(pend_id), 9);
        check("R11 second src", 32'(pend_src), 4);
        drive(12'hF00, mk(1, 1, 8'h00, 1'b0), 0);
        @(negedge clk); wr_en = 1'b0;
        check("R11 third", 32'(pend_strobe), 32'h3E);
        @(negedge clk);
        check("R1 idle after burst", 32'(pend_strobe), 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule